// File: doc/BRIEF.md
# Host Post-Code Snoop Capture FIFO

This block sits beside a host I/O bus decoder and records the bytes the host writes to one or two chosen 16-bit I/O addresses. Firmware on the host reports its power-on self-test progress this way, and a management processor reads the recorded codes later to follow or diagnose the boot. The input is an I/O write event that has already been decoded: an address, a data byte and a one-cycle strobe. A separate input carries the host reset level.

Each recorded byte goes into a FIFO with a one-bit tag. A byte-wide register port lets the management processor do the following:
- program both match addresses;
- choose which address is active;
- select a double-word mode, in which four consecutive addresses starting at address 1 are recorded;
- read status and pop data;
- clear a sticky flag that records a change of the host reset level.

A level interrupt combines "data waiting" and "host reset changed". Each of the two causes has its own enable bit.

Top module: `postcode_snoop`

## Requirements
- R1: After reset every register reads 0x00, the FIFO is empty and `irq` is low.
- R2: The register offsets are fixed as follows:
  - address 1 low byte at 0x10 and high byte at 0x12;
  - address 2 low byte at 0x02 and high byte at 0x04;
  - enable register at 0x06.

  Each of these reads back what was last written. A register read returns its value on `regRdata` one clock after the read strobe.
- R3: The enable register has these bits:
  - bit 7 turns on capture for address 1;
  - bit 6 turns on capture for address 2;
  - bit 2 selects double-word mode;
  - bit 3 enables the data-ready interrupt;
  - bit 4 enables the host-reset interrupt.

  Outside double-word mode, an I/O write whose address equals an enabled match address is stored. A write to address 1 gets tag 0 and a write to address 2 gets tag 1. If both match addresses are equal, address 1 wins.
- R4: An I/O write is not stored when its address matches no enabled address, or when only some of its address bits match.
- R5: The status register is at offset 0x08. Bit 7 is set when the FIFO holds data. Bit 5 is the sticky overflow flag. Bit 0 is the tag of the oldest entry, and reads 0 when the FIFO is empty.
- R6: Reading offset 0x0A returns the oldest byte and removes it. Bytes come out in the order they were captured.
- R7: Reading offset 0x0A while the FIFO is empty returns 0x00 and leaves the FIFO unchanged.
- R8: The FIFO holds 128 entries. A capture that arrives while the FIFO is full is dropped and sets the overflow flag, even if a pop happens in the same cycle. The flag stays set until the status register is read while the FIFO is empty. That read still returns the flag as set.
- R9: When bit 2 is set, writes to address 1 through address 1 + 3 are each stored as one byte. Bit 7 is not needed for this. The byte from address 1 + 3 carries tag 1 and the other three carry tag 0. Address 2 is ignored in this mode, even when bit 6 is set.
- R10: The host reset input passes through a two-flop synchronizer. A rising or a falling level change sets bit 6 of the register at offset 0x0C. Writing a 1 to bit 6 clears the flag, and writing a 0 there leaves it unchanged.
- R11: `irq` is high exactly while either of these holds:
  - bit 3 is set and the FIFO is not empty;
  - bit 4 is set and the host-reset flag is set.
- R12: If a capture and a data pop fall in the same cycle, both take effect. The pop returns the older byte and the new byte stays in the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioWrStb | input | 1 | One-cycle pulse for a decoded host I/O write |
| ioAddr | input | 16 | I/O address of the write |
| ioData | input | 8 | Data byte of the write |
| hostRst | input | 1 | Host reset level, asynchronous to `clk` |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regOff | input | 5 | Register offset |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data, valid one cycle after `regRd` |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume the following about the inputs:
- `regRd` and `regWr` are never high in the same cycle;
- the host reset level is low when block reset is released, so the synchronizer starts out agreeing with it.

The stimulus drives every strobe for exactly one cycle. It never combines a read with a write. It holds `hostRst` low through reset and changes it only while the block is running, with several cycles between changes so each one settles through the synchronizer. The overflow property assumes no pop while the FIFO is full, and the bench fills the FIFO without popping.

// File: rtl/postcode_snoop_pkg.sv
`timescale 1ns/1ps
package postcode_snoop_pkg;
  localparam int DATA_W = 8;
  localparam int IO_ADDR_W = 16;
  localparam int OFF_W = 5;
  localparam int DW_BYTES = 4;

  localparam logic [OFF_W-1:0] OFF_A2_LO = 5'h02;
  localparam logic [OFF_W-1:0] OFF_A2_HI = 5'h04;
  localparam logic [OFF_W-1:0] OFF_CTRL  = 5'h06;
  localparam logic [OFF_W-1:0] OFF_STAT  = 5'h08;
  localparam logic [OFF_W-1:0] OFF_DATA  = 5'h0A;
  localparam logic [OFF_W-1:0] OFF_HOST  = 5'h0C;
  localparam logic [OFF_W-1:0] OFF_A1_LO = 5'h10;
  localparam logic [OFF_W-1:0] OFF_A1_HI = 5'h12;

  localparam int EN_A1    = 7;
  localparam int EN_A2    = 6;
  localparam int EN_HIRQ  = 4;
  localparam int EN_RIRQ  = 3;
  localparam int EN_DWORD = 2;
  localparam int HOST_CHG = 6;

  typedef struct packed {
    logic              push;
    logic              pushTag;
    logic [DATA_W-1:0] pushData;
    logic              pop;
  } fifoCmd_t;
endpackage

// File: rtl/postcode_snoop_sync.sv
`timescale 1ns/1ps
module postcode_snoop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '0;
        else       chain <= asyncIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/postcode_snoop_fifo.sv
`timescale 1ns/1ps
module postcode_snoop_fifo
  import postcode_snoop_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCmd_t          cmd,
  output logic              empty,
  output logic              full,
  output logic [DATA_W-1:0] headData,
  output logic              headTag,
  output logic [CNT_W-1:0]  count
);
  logic [DATA_W:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign doPush = cmd.push && !full;
  assign doPop  = cmd.pop && !empty;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= {cmd.pushTag, cmd.pushData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign {headTag, headData} = store[rdPtr];
endmodule

// File: rtl/postcode_snoop_regs.sv
`timescale 1ns/1ps
module postcode_snoop_regs
  import postcode_snoop_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ioWrStb,
  input  logic [IO_ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0]    ioData,
  input  logic                 hostLvl,
  input  logic                 regWr,
  input  logic                 regRd,
  input  logic [OFF_W-1:0]     regOff,
  input  logic [7:0]           regWdata,
  input  logic                 fifoEmpty,
  input  logic                 fifoFull,
  input  logic [DATA_W-1:0]    fifoHeadData,
  input  logic                 fifoHeadTag,
  output fifoCmd_t             cmd,
  output logic [7:0]           regRdata,
  output logic                 irq,
  output logic [7:0]           enBits,
  output logic                 chgFlag,
  output logic                 ovfFlag
);
  logic [IO_ADDR_W-1:0] matchA1, matchA2, dwOfs;
  logic hit1, hit2, hitDw, hostPrev, hostEdge;
  logic [7:0] readVal;

  assign dwOfs = ioAddr - matchA1;
  assign hit1  = enBits[EN_A1] && (ioAddr == matchA1);
  assign hit2  = enBits[EN_A2] && (ioAddr == matchA2);
  assign hitDw = dwOfs < IO_ADDR_W'(DW_BYTES);

  always_comb begin
    cmd.pushData = ioData;
    cmd.pop      = regRd && (regOff == OFF_DATA);
    if (enBits[EN_DWORD]) begin
      cmd.push    = ioWrStb && hitDw;
      cmd.pushTag = (dwOfs == IO_ADDR_W'(DW_BYTES - 1));
    end else begin
      cmd.push    = ioWrStb && (hit1 || hit2);
      cmd.pushTag = !hit1;
    end
  end

  assign hostEdge = hostLvl ^ hostPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchA1  <= '0;
      matchA2  <= '0;
      enBits   <= '0;
      chgFlag  <= 1'b0;
      ovfFlag  <= 1'b0;
      hostPrev <= 1'b0;
    end else begin
      hostPrev <= hostLvl;
      if (regWr) begin
        case (regOff)
          OFF_A1_LO: matchA1[7:0]  <= regWdata;
          OFF_A1_HI: matchA1[15:8] <= regWdata;
          OFF_A2_LO: matchA2[7:0]  <= regWdata;
          OFF_A2_HI: matchA2[15:8] <= regWdata;
          OFF_CTRL:  enBits        <= regWdata;
          default: ;
        endcase
      end
      if (hostEdge) chgFlag <= 1'b1;
      else if (regWr && regOff == OFF_HOST && regWdata[HOST_CHG]) chgFlag <= 1'b0;
      if (cmd.push && fifoFull) ovfFlag <= 1'b1;
      else if (regRd && regOff == OFF_STAT && fifoEmpty) ovfFlag <= 1'b0;
    end
  end

  always_comb begin
    case (regOff)
      OFF_A1_LO: readVal = matchA1[7:0];
      OFF_A1_HI: readVal = matchA1[15:8];
      OFF_A2_LO: readVal = matchA2[7:0];
      OFF_A2_HI: readVal = matchA2[15:8];
      OFF_CTRL:  readVal = enBits;
      OFF_STAT:  readVal = {!fifoEmpty, 1'b0, ovfFlag, 4'b0, fifoHeadTag && !fifoEmpty};
      OFF_DATA:  readVal = fifoEmpty ? 8'h00 : fifoHeadData;
      OFF_HOST:  readVal = {1'b0, chgFlag, 6'b0};
      default:   readVal = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)      regRdata <= 8'h00;
    else if (regRd) regRdata <= readVal;
  end

  assign irq = (enBits[EN_RIRQ] && !fifoEmpty) || (enBits[EN_HIRQ] && chgFlag);
endmodule

// File: rtl/postcode_snoop.sv
`timescale 1ns/1ps
module postcode_snoop
  import postcode_snoop_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ioWrStb,
  input  logic [15:0] ioAddr,
  input  logic [7:0]  ioData,
  input  logic        hostRst,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [4:0]  regOff,
  input  logic [7:0]  regWdata,
  output logic [7:0]  regRdata,
  output logic        irq
);
  fifoCmd_t cmd;
  logic hostLvl, fifoEmpty, fifoFull, headTag, chgFlag, ovfFlag;
  logic [DATA_W-1:0] headData;
  logic [CNT_W-1:0] fifoCount;
  logic [7:0] enBits;

  postcode_snoop_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .asyncIn(hostRst), .syncOut(hostLvl)
  );

  postcode_snoop_regs regs_i (
    .clk(clk), .rstN(rstN), .ioWrStb(ioWrStb), .ioAddr(ioAddr), .ioData(ioData),
    .hostLvl(hostLvl), .regWr(regWr), .regRd(regRd), .regOff(regOff),
    .regWdata(regWdata), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull),
    .fifoHeadData(headData), .fifoHeadTag(headTag), .cmd(cmd),
    .regRdata(regRdata), .irq(irq), .enBits(enBits), .chgFlag(chgFlag),
    .ovfFlag(ovfFlag)
  );

  postcode_snoop_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .empty(fifoEmpty), .full(fifoFull),
    .headData(headData), .headTag(headTag), .count(fifoCount)
  );
endmodule

// File: rtl/postcode_snoop_chk.sv
`timescale 1ns/1ps
module postcode_snoop_chk
  import postcode_snoop_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             regRd,
  input logic [4:0]       regOff,
  input logic [7:0]       regRdata,
  input logic             irq,
  input logic [CNT_W-1:0] fifoCount,
  input logic [7:0]       enBits,
  input logic             ovfFlag
);
  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNT_W'(DEPTH));

  p_full_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount == CNT_W'(DEPTH) && !(regRd && regOff == OFF_DATA)) |=> fifoCount == CNT_W'(DEPTH));

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && fifoCount != '0) |=> ovfFlag);

  p_empty_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount == '0 && regRd && regOff == OFF_DATA) |=> regRdata == 8'h00);

  p_irq_ready_r11: assert property (@(posedge clk) disable iff (!rstN)
    (enBits[EN_RIRQ] && fifoCount != '0) |-> irq);

  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!enBits[EN_RIRQ] && !enBits[EN_HIRQ]) |-> !irq);

  p_single_step_r12: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (fifoCount <= $past(fifoCount) + 1'b1) && (fifoCount + 1'b1 >= $past(fifoCount)));
endmodule

bind postcode_snoop postcode_snoop_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .regRd(regRd), .regOff(regOff), .regRdata(regRdata),
  .irq(irq), .fifoCount(fifoCount), .enBits(enBits), .ovfFlag(ovfFlag)
);

// File: tb/postcode_snoop_tb_top.sv
`timescale 1ns/1ps
module postcode_snoop_tb_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic ioWrStb = 1'b0, hostRst = 1'b0, regWr = 1'b0, regRd = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [7:0] ioData = '0, regWdata = '0, regRdata;
  logic [4:0] regOff = '0;
  logic irq;
  int checks = 0, failures = 0;

  localparam logic [4:0] A2L = 5'h02, A2H = 5'h04, CTL = 5'h06, STA = 5'h08,
                         DAT = 5'h0A, HST = 5'h0C, A1L = 5'h10, A1H = 5'h12;

  // {address, data, expect stored, expect tag}
  localparam int NV = 7;
  localparam logic [25:0] VEC [NV] = '{
    {16'h0080, 8'h3C, 1'b1, 1'b0},
    {16'h0084, 8'hA5, 1'b1, 1'b1},
    {16'h0081, 8'h11, 1'b0, 1'b0},
    {16'h0080, 8'h00, 1'b1, 1'b0},
    {16'h0184, 8'h77, 1'b0, 1'b0},
    {16'h0084, 8'hFF, 1'b1, 1'b1},
    {16'h8080, 8'h42, 1'b0, 1'b0}
  };

  postcode_snoop dut_i (
    .clk(clk), .rstN(rstN), .ioWrStb(ioWrStb), .ioAddr(ioAddr), .ioData(ioData),
    .hostRst(hostRst), .regWr(regWr), .regRd(regRd), .regOff(regOff),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] off, logic [7:0] d);
    @(negedge clk); regWr = 1'b1; regOff = off; regWdata = d;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rd(logic [4:0] off, output logic [7:0] d);
    @(negedge clk); regRd = 1'b1; regOff = off;
    @(negedge clk); regRd = 1'b0; d = regRdata;
  endtask

  task automatic expectReg(string req, logic [4:0] off, logic [7:0] exp);
    logic [7:0] v;
    rd(off, v);
    check(req, v, exp);
  endtask

  task automatic ioWrite(logic [15:0] a, logic [7:0] d);
    @(negedge clk); ioWrStb = 1'b1; ioAddr = a; ioData = d;
    @(negedge clk); ioWrStb = 1'b0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [7:0] v;
    int bad;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 irq", {7'b0, irq}, 8'h00);
    expectReg("R1 status", STA, 8'h00);
    expectReg("R1 enable", CTL, 8'h00);
    expectReg("R1 host flag", HST, 8'h00);
    expectReg("R1 addr1 lo", A1L, 8'h00);
    // R2 address registers
    wr(A1L, 8'h80); wr(A1H, 8'h00); wr(A2L, 8'h84); wr(A2H, 8'h00);
    wr(A1H, 8'h5A); expectReg("R2 addr1 hi", A1H, 8'h5A); wr(A1H, 8'h00);
    expectReg("R2 addr2 lo", A2L, 8'h84);
    wr(CTL, 8'hC0);
    expectReg("R2 enable", CTL, 8'hC0);
    // R3/R4/R5/R6 vector table
    for (int i = 0; i < NV; i++) begin
      ioWrite(VEC[i][25:10], VEC[i][9:2]);
      expectReg(VEC[i][1] ? "R3 R5 stored status" : "R4 not stored status", STA,
                {VEC[i][1], 6'b0, VEC[i][0]});
      if (VEC[i][1]) begin
        expectReg("R6 data pop", DAT, VEC[i][9:2]);
        expectReg("R6 empty after pop", STA, 8'h00);
      end
    end
    // R6 ordering, R4 disabled address
    wr(CTL, 8'h80);
    ioWrite(16'h0084, 8'h99);
    ioWrite(16'h0080, 8'h01); ioWrite(16'h0080, 8'h02);
    expectReg("R6 order first", DAT, 8'h01);
    expectReg("R6 order second", DAT, 8'h02);
    expectReg("R4 disabled addr2 ignored", STA, 8'h00);
    // R7 empty read
    expectReg("R7 empty data read", DAT, 8'h00);
    ioWrite(16'h0080, 8'h3D);
    expectReg("R7 pointers unchanged", DAT, 8'h3D);
    // R11 interrupt from data
    check("R11 irq disabled", {7'b0, irq}, 8'h00);
    wr(CTL, 8'h88);
    ioWrite(16'h0080, 8'h21);
    check("R11 irq data ready", {7'b0, irq}, 8'h01);
    wr(CTL, 8'h80);
    check("R11 irq masked", {7'b0, irq}, 8'h00);
    wr(CTL, 8'h88);
    expectReg("R11 pop", DAT, 8'h21);
    check("R11 irq after drain", {7'b0, irq}, 8'h00);
    // R12 simultaneous capture and pop
    wr(CTL, 8'h80);
    ioWrite(16'h0080, 8'h55);
    @(negedge clk);
    ioWrStb = 1'b1; ioAddr = 16'h0080; ioData = 8'h66; regRd = 1'b1; regOff = DAT;
    @(negedge clk);
    ioWrStb = 1'b0; regRd = 1'b0;
    check("R12 pop returns older", regRdata, 8'h55);
    expectReg("R12 new byte kept", STA, 8'h80);
    expectReg("R12 new byte data", DAT, 8'h66);
    expectReg("R12 empty", STA, 8'h00);
    // R9 double-word mode
    wr(CTL, 8'h44);
    ioWrite(16'h0080, 8'h11); ioWrite(16'h0081, 8'h22);
    ioWrite(16'h0082, 8'h33); ioWrite(16'h0084, 8'h99);
    ioWrite(16'h007F, 8'h88); ioWrite(16'h0083, 8'h44);
    expectReg("R9 byte0 tag", STA, 8'h80); expectReg("R9 byte0", DAT, 8'h11);
    expectReg("R9 byte1 tag", STA, 8'h80); expectReg("R9 byte1", DAT, 8'h22);
    expectReg("R9 byte2 tag", STA, 8'h80); expectReg("R9 byte2", DAT, 8'h33);
    expectReg("R9 byte3 tag", STA, 8'h81); expectReg("R9 byte3", DAT, 8'h44);
    expectReg("R9 addr2 ignored", STA, 8'h00);
    // R8 overflow
    wr(CTL, 8'h80);
    for (int i = 0; i < 129; i++) ioWrite(16'h0080, 8'(i));
    expectReg("R8 full with overflow", STA, 8'hA0);
    bad = 0;
    for (int i = 0; i < 128; i++) begin
      rd(DAT, v);
      if (v !== 8'(i)) bad++;
    end
    check("R8 128 entries kept, extra dropped", 8'(bad), 8'h00);
    expectReg("R8 drained", DAT, 8'h00);
    expectReg("R8 overflow still reported", STA, 8'h20);
    expectReg("R8 overflow cleared", STA, 8'h00);
    // R10 host reset change tracking
    wr(CTL, 8'h10);
    hostRst = 1'b1;
    repeat (5) @(negedge clk);
    expectReg("R10 rising edge", HST, 8'h40);
    check("R11 irq host reset", {7'b0, irq}, 8'h01);
    wr(HST, 8'h00);
    expectReg("R10 write zero keeps", HST, 8'h40);
    wr(HST, 8'h40);
    expectReg("R10 write one clears", HST, 8'h00);
    check("R11 irq cleared", {7'b0, irq}, 8'h00);
    hostRst = 1'b0;
    repeat (5) @(negedge clk);
    expectReg("R10 falling edge", HST, 8'h40);
    wr(HST, 8'h40);
    finishRun();
  end
endmodule